// File: doc/BRIEF.md
# Two-Vector Scan Chain with Hold Stage

This block is a serial test chain in which every position owns two storage bits. The first bit is a flip-flop that either samples the functional response or shifts toward the serial output. The second bit is a hold stage that drives the logic under test. While the chain is in test, the hold stage stays closed. A new vector can therefore be shifted into the flip-flops while the logic under test still sees the previous one. A single update cycle then launches the new vector, so the two vectors of a delay test never constrain each other.

Outside test the hold stage is bypassed, so each position acts as an ordinary flip-flop between its functional input and output. A built-in sequencer can run a whole delay test without help. It takes an initialising vector and a launching vector, and it shifts the first in and updates it onto the outputs. It then shifts the second in behind the held first, updates it (the launch), captures the response on the next clock and shifts the response out into a result register. While the sequencer runs, it owns the chain controls and the external test pins have no effect.

Top module: `dual_vec_scan`

## Requirements
- R1: Reset is asserted asynchronously and released two clocks after rst_n rises. While reset is active and right after release, cut_in, scan_out, seq_busy, seq_done and seq_resp are all zero.
- R2: On a clock with scan enable high, every flip-flop takes the value of its lower neighbour and cell 0 takes scan_in. scan_out is always the flip-flop of cell CELLS-1. A vector shifted in with its top bit first therefore ends with bit i in cell i.
- R3: On a clock with scan enable low, every flip-flop loads its func_d bit.
- R4: With test_mode low, cut_in equals the flip-flop contents, so the chain acts as a plain register from func_d to cut_in.
- R5: With test_mode high and hold_upd low, cut_in does not change, whatever is shifted or captured.
- R6: A clock with test_mode and hold_upd both high copies the flip-flop contents, as they stood before that edge, onto cut_in.
- R7: After seq_start is taken in idle, the sequencer shifts seq_vec1 in and updates it onto cut_in. It then keeps cut_in equal to seq_vec1 for the whole time seq_vec2 is being shifted.
- R8: The sequencer updates seq_vec2 onto cut_in and captures func_d on the next clock. It then shifts the captured word out and presents it on seq_resp, with bit i equal to func_d[i] as driven by the logic under test while cut_in held seq_vec2. It pulses seq_done high for exactly one cycle as seq_busy falls. Each update pulse lasts one cycle.
- R9: While seq_busy is high, the external scan_en, hold_upd, test_mode and scan_in have no effect on the chain.
- R10: A seq_start while seq_busy is high is ignored, and the running test completes with its original vectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_mode | input | 1 | External: 1 closes the hold stages (test), 0 bypasses them |
| scan_en | input | 1 | External: 1 shifts, 0 captures func_d |
| hold_upd | input | 1 | External: copy flip-flops onto hold stages at this clock (test mode) |
| scan_in | input | 1 | External serial input to cell 0 |
| scan_out | output | 1 | Serial output, flip-flop of the last cell |
| func_d | input | CELLS | Response of the logic under test, one bit per cell |
| cut_in | output | CELLS | Stimulus to the logic under test, one bit per cell |
| seq_start | input | 1 | Start a sequenced two-vector test (taken when idle) |
| seq_vec1 | input | CELLS | Initialising vector |
| seq_vec2 | input | CELLS | Launching vector |
| seq_busy | output | 1 | Sequencer running and owning the chain controls |
| seq_done | output | 1 | One-cycle pulse at the end of a sequenced test |
| seq_resp | output | CELLS | Response captured after the launch |

## Verification
A hold stage that wrongly follows the flip-flops shows up at cut_in during the next shift clock. That is one cycle after the corruption, and in the middle of the second vector's load, well before the launch. A flip-flop that shifts or captures the wrong bit shows up later: only after the full unload, as a mismatch in seq_resp or in the scan_out sequence. An extra cycle or a missing cycle in the sequencer moves every bit of the response by one position, so a single run exposes it. A sequencer that leaks the external pins corrupts cut_in or seq_resp within the same run.

// File: rtl/dvs_pkg.sv
package dvs_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_LD1,
    S_UP1,
    S_LD2,
    S_UP2,
    S_CAP,
    S_UNL
  } seq_st_t;
endpackage

// File: rtl/dvs_cell.sv
module dvs_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic scan_en,
  input  logic ser_i,
  input  logic func_i,
  input  logic test_mode,
  input  logic upd,
  output logic ff_q,
  output logic cut_o
);
  logic ff_d;
  logic hold_q;
  logic hold_d;
  logic hold_en;

  always_comb begin
    ff_d    = scan_en ? ser_i : func_i;
    hold_en = upd || !test_mode;
    hold_d  = hold_en ? ff_q : hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ff_q   <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      ff_q   <= ff_d;
      hold_q <= hold_d;
    end
  end

  assign cut_o = test_mode ? hold_q : ff_q;
endmodule

// File: rtl/dvs_chain.sv
module dvs_chain #(
  parameter int CELLS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scan_en,
  input  logic             scan_in,
  input  logic             test_mode,
  input  logic             upd,
  input  logic [CELLS-1:0] func_d,
  output logic [CELLS-1:0] cut_o,
  output logic             scan_out
);
  logic [CELLS-1:0] ff_q;
  logic [CELLS-1:0] ser;

  assign ser = {ff_q[CELLS-2:0], scan_in};

  for (genvar g = 0; g < CELLS; g++) begin : g_cell
    dvs_cell u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .scan_en  (scan_en),
      .ser_i    (ser[g]),
      .func_i   (func_d[g]),
      .test_mode(test_mode),
      .upd      (upd),
      .ff_q     (ff_q[g]),
      .cut_o    (cut_o[g])
    );
  end

  assign scan_out = ff_q[CELLS-1];

  p_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    scan_en |=> (ff_q == {$past(ff_q[CELLS-2:0]), $past(scan_in)}));

  p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |=> (ff_q == $past(func_d)));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && !upd) ##1 test_mode |-> $stable(cut_o));

  p_update_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && upd) ##1 test_mode |-> (cut_o == $past(ff_q)));
endmodule

// File: rtl/dvs_seq.sv
module dvs_seq
  import dvs_pkg::*;
#(
  parameter int CELLS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CELLS-1:0] vec1,
  input  logic [CELLS-1:0] vec2,
  input  logic             ser_ret,
  output logic             se,
  output logic             si,
  output logic             upd,
  output logic             busy,
  output logic             done,
  output logic [CELLS-1:0] resp
);
  localparam int CW = (CELLS > 1) ? $clog2(CELLS) : 1;
  localparam logic [CW-1:0] LAST = CW'(CELLS - 1);

  seq_st_t          st_q, st_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [CELLS-1:0] sh_q, sh_d;
  logic [CELLS-1:0] v2_q, v2_d;
  logic [CELLS-1:0] resp_q, resp_d;
  logic             done_q, done_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    v2_d   = v2_q;
    resp_d = resp_q;
    done_d = 1'b0;
    se     = 1'b0;
    upd    = 1'b0;
    case (st_q)
      S_IDLE: begin
        if (start) begin
          st_d  = S_LD1;
          sh_d  = vec1;
          v2_d  = vec2;
          cnt_d = '0;
        end
      end
      S_LD1, S_LD2: begin
        se   = 1'b1;
        sh_d = {sh_q[CELLS-2:0], 1'b0};
        if (cnt_q == LAST) st_d = (st_q == S_LD1) ? S_UP1 : S_UP2;
        else               cnt_d = cnt_q + 1'b1;
      end
      S_UP1: begin
        se    = 1'b1;
        upd   = 1'b1;
        sh_d  = v2_q;
        cnt_d = '0;
        st_d  = S_LD2;
      end
      S_UP2: begin
        se   = 1'b1;
        upd  = 1'b1;
        st_d = S_CAP;
      end
      S_CAP: begin
        cnt_d = '0;
        st_d  = S_UNL;
      end
      S_UNL: begin
        se     = 1'b1;
        resp_d = {resp_q[CELLS-2:0], ser_ret};
        if (cnt_q == LAST) begin
          st_d   = S_IDLE;
          done_d = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      cnt_q  <= '0;
      sh_q   <= '0;
      v2_q   <= '0;
      resp_q <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      v2_q   <= v2_d;
      resp_q <= resp_d;
      done_q <= done_d;
    end
  end

  assign si   = sh_q[CELLS-1];
  assign busy = (st_q != S_IDLE);
  assign done = done_q;
  assign resp = resp_q;

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_upd_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> !upd);

  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(v2_q));
endmodule

// File: rtl/dual_vec_scan.sv
module dual_vec_scan #(
  parameter int CELLS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             test_mode,
  input  logic             scan_en,
  input  logic             hold_upd,
  input  logic             scan_in,
  output logic             scan_out,
  input  logic [CELLS-1:0] func_d,
  output logic [CELLS-1:0] cut_in,
  input  logic             seq_start,
  input  logic [CELLS-1:0] seq_vec1,
  input  logic [CELLS-1:0] seq_vec2,
  output logic             seq_busy,
  output logic             seq_done,
  output logic [CELLS-1:0] seq_resp
);
  logic rs_q1, rs_q2;
  logic srst_n;
  logic q_se, q_si, q_upd;
  logic c_se, c_si, c_upd, c_tm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q1 <= 1'b0;
      rs_q2 <= 1'b0;
    end else begin
      rs_q1 <= 1'b1;
      rs_q2 <= rs_q1;
    end
  end
  assign srst_n = rs_q2;

  dvs_seq #(.CELLS(CELLS)) u_seq (
    .clk    (clk),
    .rst_n  (srst_n),
    .start  (seq_start),
    .vec1   (seq_vec1),
    .vec2   (seq_vec2),
    .ser_ret(scan_out),
    .se     (q_se),
    .si     (q_si),
    .upd    (q_upd),
    .busy   (seq_busy),
    .done   (seq_done),
    .resp   (seq_resp)
  );

  always_comb begin
    if (seq_busy) begin
      c_se  = q_se;
      c_si  = q_si;
      c_upd = q_upd;
      c_tm  = 1'b1;
    end else begin
      c_se  = scan_en;
      c_si  = scan_in;
      c_upd = hold_upd;
      c_tm  = test_mode;
    end
  end

  dvs_chain #(.CELLS(CELLS)) u_chain (
    .clk      (clk),
    .rst_n    (srst_n),
    .scan_en  (c_se),
    .scan_in  (c_si),
    .test_mode(c_tm),
    .upd      (c_upd),
    .func_d   (func_d),
    .cut_o    (cut_in),
    .scan_out (scan_out)
  );

  p_busy_holds_r9: assert property (@(posedge clk) disable iff (!srst_n)
    (seq_busy && !q_upd) ##1 seq_busy |-> $stable(cut_in));
endmodule

// File: tb/sim_dual_vec_scan.sv
module sim_dual_vec_scan;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tm = 1'b1, se = 1'b0, upd = 1'b0, si = 1'b0;
  logic so;
  logic [N-1:0] ext_func = '0;
  logic use_cut = 1'b0;
  logic [N-1:0] func_d, cut_in;
  logic start = 1'b0;
  logic [N-1:0] v1 = '0, v2 = '0;
  logic busy, done;
  logic [N-1:0] resp;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  function automatic logic [N-1:0] cutf(input logic [N-1:0] x);
    return {x[N-2:0], x[N-1]} ^ (x >> 2) ^ 8'h3C;
  endfunction

  assign func_d = use_cut ? cutf(cut_in) : ext_func;

  dual_vec_scan #(.CELLS(N)) u0 (
    .clk(clk), .rst_n(rst_n), .test_mode(tm), .scan_en(se), .hold_upd(upd),
    .scan_in(si), .scan_out(so), .func_d(func_d), .cut_in(cut_in),
    .seq_start(start), .seq_vec1(v1), .seq_vec2(v2), .seq_busy(busy),
    .seq_done(done), .seq_resp(resp)
  );

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic shift_in(input logic [N-1:0] p);
    for (int i = N - 1; i >= 0; i--) begin
      si = p[i];
      @(negedge clk);
    end
  endtask

  // [16] hostile pins + restart during run, [15:8] vec1, [7:0] vec2
  localparam logic [16:0] TV [0:5] = '{
    17'h0_00FF, 17'h0_FF00, 17'h0_A55A, 17'h1_3CC3, 17'h0_7E7E, 17'h1_8001
  };

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 cut_in in reset", cut_in, '0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 cut_in", cut_in, '0);
    chk("R1 scan_out", {7'd0, so}, '0);
    chk("R1 busy/done", {6'd0, busy, done}, '0);
    chk("R1 resp", resp, '0);

    se = 1'b1;
    shift_in(8'hC9);
    chk("R2 scan_out after load", {7'd0, so}, 8'h01);
    se = 1'b0; upd = 1'b1; ext_func = 8'h00;
    @(negedge clk);
    chk("R6 update copies chain", cut_in, 8'hC9);
    upd = 1'b0; se = 1'b1;
    shift_in(8'h36);
    chk("R5 hold during shift", cut_in, 8'hC9);
    chk("R2 scan_out top bit", {7'd0, so}, 8'h00);
    si = 1'b0;
    @(negedge clk);
    chk("R2 scan_out next bit", {7'd0, so}, 8'h00);
    shift_in(8'h80);
    chk("R2 scan_out walked bit", {7'd0, so}, 8'h01);
    chk("R5 hold still", cut_in, 8'hC9);

    se = 1'b0; ext_func = 8'h5D;
    @(negedge clk);
    chk("R5 hold during capture", cut_in, 8'hC9);
    upd = 1'b1;
    @(negedge clk);
    upd = 1'b0;
    chk("R3 capture then update", cut_in, 8'h5D);

    tm = 1'b0; ext_func = 8'hE2;
    @(negedge clk);
    chk("R4 normal mode register", cut_in, 8'hE2);
    ext_func = 8'h19;
    @(negedge clk);
    chk("R4 normal mode follows", cut_in, 8'h19);
    tm = 1'b1;

    use_cut = 1'b1;
    for (int k = 0; k < 6; k++) begin
      logic hostile;
      logic [N-1:0] a, b;
      hostile = TV[k][16];
      a = TV[k][15:8];
      b = TV[k][7:0];
      v1 = a; v2 = b; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R8 busy after start", {7'd0, busy}, 8'h01);
      if (hostile) begin
        tm = 1'b0; se = 1'b0; upd = 1'b1; si = 1'b1;
      end
      repeat (N + 4) @(negedge clk);
      chk("R7 vec1 held during vec2 shift", cut_in, a);
      if (hostile) begin
        v1 = ~a; v2 = ~b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R9 external pins ignored", cut_in, a);
        tm = 1'b1; se = 1'b0; upd = 1'b0; si = 1'b0;
      end
      for (int w = 0; w < 100 && !done; w++) @(negedge clk);
      chk("R8 done seen", {7'd0, done}, 8'h01);
      chk(hostile ? "R10 resp after restart attempt" : "R8 response", resp, cutf(b));
      chk("R8 vec2 on cut_in", cut_in, b);
      @(negedge clk);
      chk("R8 done single pulse, idle", {6'd0, done, busy}, 8'h00);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule